// File: doc/BRIEF.md
# Two-Dimensional Strided Beat Address Sequencer

This block turns one memory-side transfer descriptor into a stream of beat addresses. A descriptor holds a base address, a row length in bytes and a row count, both written as the value minus one, a row stride in bytes, and a replay flag. The block visits the region row by row. Each row begins one stride after the start of the row before it, whatever the row length. Within a row the address climbs by the bus width on every beat. The last beat of each row carries an end-of-row flag, and the last beat of the whole region carries a pass-end flag. A single-cycle done pulse follows the acceptance of that beat.

The descriptor arrives on a valid/ready handshake, and the block takes one only while it is idle and enabled. Beats leave on a second valid/ready handshake. If the replay flag is set, the block goes back to the base address after the final row and keeps going until enable is dropped. Clearing enable stops the walk at the next accepted beat. The block then returns to idle and can take a new descriptor.

Top module: `s2d_addr_gen`

## Requirements
- R1: Both lengths use the minus-one encoding. Each row has floor(x_m1 / BEAT_BYTES) + 1 beats, so a row length that is not a multiple of the bus width rounds up to whole beats. A pass has y_m1 + 1 rows.
- R2: The first beat of row k (counting from 0) is at aligned base + k × aligned stride, modulo 2^ADDR_W.
- R3: Within a row, each beat is BEAT_BYTES above the one before it. beat_eor is 1 exactly on the last beat of a row.
- R4: When y_m1 is 0 the stride has no effect, including on replayed passes.
- R5: The low log2(BEAT_BYTES) bits of base and stride are ignored. Every offered beat address is a multiple of BEAT_BYTES.
- R6: beat_last is 1 exactly on the final beat of the final row. done is 1 for the single cycle after that beat is accepted, and 0 at all other times.
- R7: When desc_cyclic is 1, the beat that follows an accepted pass-final beat is at the aligned base again, with no new descriptor. done pulses once per pass.
- R8: If enable is 0 when a beat is accepted, no further beat is offered and the block goes idle. done still pulses if that beat was pass-final.
- R9: While beat_valid is 1 and beat_ready is 0, beat_valid stays 1 and beat_addr, beat_eor and beat_last hold their values.
- R10: desc_ready is 1 only while no beat is offered and enable is 1. The first beat is offered in the cycle after the descriptor is accepted. A non-replaying pass returns the block to desc_ready = 1 once its final beat is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run permission; 0 stops at the next accepted beat |
| desc_valid | input | 1 | Descriptor offered |
| desc_ready | output | 1 | Descriptor can be taken |
| desc_base | input | ADDR_W | Base byte address |
| desc_x_m1 | input | X_W | Row length in bytes minus one |
| desc_y_m1 | input | Y_W | Row count minus one |
| desc_stride | input | STRIDE_W | Byte distance between row starts |
| desc_cyclic | input | 1 | Replay the region until disabled |
| beat_valid | output | 1 | Beat address offered |
| beat_ready | input | 1 | Consumer takes the beat |
| beat_addr | output | ADDR_W | Beat byte address |
| beat_eor | output | 1 | Beat is the last of its row |
| beat_last | output | 1 | Beat is the last of the pass |
| done | output | 1 | One-cycle pulse after the pass-final beat is accepted |

## Verification
A column counter that goes wrong shows up at the first end-of-row flag or the first row start that follows it. Either one is a mismatch within one row of beats. A bad row-start accumulator shows at the first beat of the second row, and a faulty replay path shows at the first beat after a pass ends. Handshake faults show within one cycle: an address that moves under back-pressure, a done pulse that lands in the wrong cycle, or a beat still offered after a disabled acceptance. The sweep covers every combination of row length and row count in a small configuration, with and without stalls, so that each of these points is reached.

// File: rtl/s2d_pkg.sv
package s2d_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } s2d_state_e;

  // Clear the low 'shift' bits of a byte value.
  function automatic logic [31:0] align_down(logic [31:0] v, int unsigned shift);
    return (v >> shift) << shift;
  endfunction

  // Beats in a row, minus one, from a minus-one byte length.
  function automatic logic [31:0] row_beats_m1(logic [31:0] x_m1, int unsigned shift);
    return x_m1 >> shift;
  endfunction

endpackage

// File: rtl/s2d_desc_latch.sv
module s2d_desc_latch
  import s2d_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int X_W        = 8,
  parameter int Y_W        = 4,
  parameter int STRIDE_W   = 12,
  parameter int BEAT_BYTES = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [ADDR_W-1:0]   in_base,
  input  logic [X_W-1:0]      in_x_m1,
  input  logic [Y_W-1:0]      in_y_m1,
  input  logic [STRIDE_W-1:0] in_stride,
  input  logic                in_cyclic,
  output logic [ADDR_W-1:0]   base_now,
  output logic [ADDR_W-1:0]   base_q,
  output logic [ADDR_W-1:0]   stride_q,
  output logic [X_W-$clog2(BEAT_BYTES)-1:0] beats_m1_q,
  output logic [Y_W-1:0]      rows_m1_q,
  output logic                cyclic_q
);
  localparam int SH    = $clog2(BEAT_BYTES);
  localparam int COL_W = X_W - SH;

  logic [ADDR_W-1:0] stride_now;
  logic [COL_W-1:0]  beats_now;

  assign base_now   = ADDR_W'(align_down(32'(in_base), SH));
  assign stride_now = ADDR_W'(align_down(32'(in_stride), SH));
  assign beats_now  = COL_W'(row_beats_m1(32'(in_x_m1), SH));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q     <= '0;
      stride_q   <= '0;
      beats_m1_q <= '0;
      rows_m1_q  <= '0;
      cyclic_q   <= 1'b0;
    end else if (load) begin
      base_q     <= base_now;
      stride_q   <= stride_now;
      beats_m1_q <= beats_now;
      rows_m1_q  <= in_y_m1;
      cyclic_q   <= in_cyclic;
    end
  end
endmodule

// File: rtl/s2d_walker.sv
module s2d_walker #(
  parameter int ADDR_W     = 16,
  parameter int Y_W        = 4,
  parameter int COL_W      = 6,
  parameter int BEAT_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic [ADDR_W-1:0] load_base,
  input  logic [ADDR_W-1:0] base_q,
  input  logic [ADDR_W-1:0] stride_q,
  input  logic [COL_W-1:0]  beats_m1_q,
  input  logic [Y_W-1:0]    rows_m1_q,
  output logic [ADDR_W-1:0] addr,
  output logic              row_end,
  output logic              pass_end
);
  localparam logic [ADDR_W-1:0] BEAT_INC = ADDR_W'(BEAT_BYTES);

  logic [COL_W-1:0]  col_q;
  logic [Y_W-1:0]    row_q;
  logic [ADDR_W-1:0] row_start_q;
  logic [ADDR_W-1:0] col_off_q;

  assign addr     = row_start_q + col_off_q;
  assign row_end  = (col_q == beats_m1_q);
  assign pass_end = row_end && (row_q == rows_m1_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q       <= '0;
      row_q       <= '0;
      row_start_q <= '0;
      col_off_q   <= '0;
    end else if (load) begin
      col_q       <= '0;
      row_q       <= '0;
      row_start_q <= load_base;
      col_off_q   <= '0;
    end else if (step) begin
      if (row_end) begin
        col_q     <= '0;
        col_off_q <= '0;
        if (pass_end) begin
          row_q       <= '0;
          row_start_q <= base_q;
        end else begin
          row_q       <= row_q + 1'b1;
          row_start_q <= row_start_q + stride_q;
        end
      end else begin
        col_q     <= col_q + 1'b1;
        col_off_q <= col_off_q + BEAT_INC;
      end
    end
  end
endmodule

// File: rtl/s2d_ctrl.sv
module s2d_ctrl
  import s2d_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic desc_valid,
  input  logic fire,
  input  logic pass_end,
  input  logic cyclic_q,
  output logic desc_ready,
  output logic load,
  output logic running,
  output logic done
);
  s2d_state_e state_q, state_d;
  logic       done_q;

  assign running    = (state_q == ST_RUN);
  assign desc_ready = (state_q == ST_IDLE) && enable;
  assign load       = desc_valid && desc_ready;
  assign done       = done_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (load) state_d = ST_RUN;
      ST_RUN: begin
        if (fire) begin
          if (!enable)                   state_d = ST_IDLE;
          else if (pass_end && !cyclic_q) state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= fire && pass_end;
    end
  end
endmodule

// File: rtl/s2d_addr_gen.sv
module s2d_addr_gen #(
  parameter int ADDR_W     = 16,
  parameter int X_W        = 8,
  parameter int Y_W        = 4,
  parameter int STRIDE_W   = 12,
  parameter int BEAT_BYTES = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                enable,
  input  logic                desc_valid,
  output logic                desc_ready,
  input  logic [ADDR_W-1:0]   desc_base,
  input  logic [X_W-1:0]      desc_x_m1,
  input  logic [Y_W-1:0]      desc_y_m1,
  input  logic [STRIDE_W-1:0] desc_stride,
  input  logic                desc_cyclic,
  output logic                beat_valid,
  input  logic                beat_ready,
  output logic [ADDR_W-1:0]   beat_addr,
  output logic                beat_eor,
  output logic                beat_last,
  output logic                done
);
  localparam int SH    = $clog2(BEAT_BYTES);
  localparam int COL_W = X_W - SH;

  // Named internal events, visible to the bound checker.
  logic              load;
  logic              fire;
  logic              row_end;
  logic              pass_end;
  logic              running;
  logic              cyclic_q;
  logic [ADDR_W-1:0] base_now, base_q, stride_q;
  logic [COL_W-1:0]  beats_m1_q;
  logic [Y_W-1:0]    rows_m1_q;

  assign fire       = running && beat_ready;
  assign beat_valid = running;
  assign beat_eor   = row_end;
  assign beat_last  = pass_end;

  s2d_desc_latch #(
    .ADDR_W(ADDR_W), .X_W(X_W), .Y_W(Y_W),
    .STRIDE_W(STRIDE_W), .BEAT_BYTES(BEAT_BYTES)
  ) u_latch (
    .clk(clk), .rst_n(rst_n), .load(load),
    .in_base(desc_base), .in_x_m1(desc_x_m1), .in_y_m1(desc_y_m1),
    .in_stride(desc_stride), .in_cyclic(desc_cyclic),
    .base_now(base_now), .base_q(base_q), .stride_q(stride_q),
    .beats_m1_q(beats_m1_q), .rows_m1_q(rows_m1_q), .cyclic_q(cyclic_q)
  );

  s2d_walker #(
    .ADDR_W(ADDR_W), .Y_W(Y_W), .COL_W(COL_W), .BEAT_BYTES(BEAT_BYTES)
  ) u_walk (
    .clk(clk), .rst_n(rst_n), .load(load), .step(fire),
    .load_base(base_now), .base_q(base_q), .stride_q(stride_q),
    .beats_m1_q(beats_m1_q), .rows_m1_q(rows_m1_q),
    .addr(beat_addr), .row_end(row_end), .pass_end(pass_end)
  );

  s2d_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .enable(enable), .desc_valid(desc_valid),
    .fire(fire), .pass_end(pass_end), .cyclic_q(cyclic_q),
    .desc_ready(desc_ready), .load(load), .running(running), .done(done)
  );
endmodule

// File: rtl/s2d_addr_gen_chk.sv
module s2d_addr_gen_chk #(
  parameter int ADDR_W     = 16,
  parameter int BEAT_BYTES = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              enable,
  input logic              desc_ready,
  input logic              beat_valid,
  input logic              beat_ready,
  input logic [ADDR_W-1:0] beat_addr,
  input logic              beat_eor,
  input logic              beat_last,
  input logic              done,
  input logic              fire
);
  localparam logic [ADDR_W-1:0] INC = ADDR_W'(BEAT_BYTES);

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && !beat_ready |=> beat_valid && $stable(beat_addr)
                                  && $stable(beat_eor) && $stable(beat_last));

  assert_aligned_R5: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid |-> (beat_addr % INC) == '0);

  assert_row_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !beat_eor && enable |=> beat_valid && beat_addr == $past(beat_addr) + INC);

  assert_done_after_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fire && beat_last |=> done);

  assert_no_stray_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(fire && beat_last) |=> !done);

  assert_abort_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !enable |=> !beat_valid);

  assert_ready_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    desc_ready |-> !beat_valid && enable);
endmodule

bind s2d_addr_gen s2d_addr_gen_chk #(.ADDR_W(ADDR_W), .BEAT_BYTES(BEAT_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .desc_ready(desc_ready),
  .beat_valid(beat_valid), .beat_ready(beat_ready), .beat_addr(beat_addr),
  .beat_eor(beat_eor), .beat_last(beat_last), .done(done), .fire(fire)
);

// File: tb/sim_s2d_addr_gen.sv
`timescale 1ns/1ps
module sim_s2d_addr_gen;
  localparam int ADDR_W = 16, X_W = 8, Y_W = 4, STRIDE_W = 12, BB = 4;

  logic clk = 1'b0, rst_n = 1'b0, enable = 1'b0;
  logic desc_valid = 1'b0, desc_cyclic = 1'b0, beat_ready = 1'b0;
  logic [ADDR_W-1:0] desc_base = '0;
  logic [X_W-1:0] desc_x_m1 = '0;
  logic [Y_W-1:0] desc_y_m1 = '0;
  logic [STRIDE_W-1:0] desc_stride = '0;
  logic desc_ready, beat_valid, beat_eor, beat_last, done;
  logic [ADDR_W-1:0] beat_addr;

  int n_chk = 0, n_bad = 0, cyc = 0;

  always #5 clk = ~clk;

  s2d_addr_gen #(.ADDR_W(ADDR_W), .X_W(X_W), .Y_W(Y_W), .STRIDE_W(STRIDE_W),
                 .BEAT_BYTES(BB)) u0 (
    .clk(clk), .rst_n(rst_n), .enable(enable), .desc_valid(desc_valid),
    .desc_ready(desc_ready), .desc_base(desc_base), .desc_x_m1(desc_x_m1),
    .desc_y_m1(desc_y_m1), .desc_stride(desc_stride), .desc_cyclic(desc_cyclic),
    .beat_valid(beat_valid), .beat_ready(beat_ready), .beat_addr(beat_addr),
    .beat_eor(beat_eor), .beat_last(beat_last), .done(done));

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog: act=%0d cycles exp<150000", cyc);
      summary();
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  // Advance one clock; done must match whether a pass-final beat was just taken.
  task automatic step(input bit exp_done);
    @(negedge clk);
    chk(done == exp_done, "R6 done", 32'(done), 32'(exp_done));
    beat_ready = 1'b0;
  endtask

  task automatic take_beat(input logic [ADDR_W-1:0] ea, input bit eeor,
                           input bit elast, input int stall);
    for (int s = 0; s < stall; s++) begin
      beat_ready = 1'b0;
      #1;
      chk(beat_valid && beat_addr == ea, "R9 hold", 32'(beat_addr), 32'(ea));
      step(1'b0);
    end
    beat_ready = 1'b1;
    #1;
    chk(beat_valid == 1'b1, "R10 valid", 32'(beat_valid), 32'd1);
    chk(beat_addr == ea, "R2 R3 addr", 32'(beat_addr), 32'(ea));
    chk(beat_eor == eeor, "R3 eor", 32'(beat_eor), 32'(eeor));
    chk(beat_last == elast, "R6 last", 32'(beat_last), 32'(elast));
    step(elast);
  endtask

  task automatic submit(input logic [ADDR_W-1:0] b, input logic [X_W-1:0] xm1,
                        input logic [Y_W-1:0] ym1, input logic [STRIDE_W-1:0] st,
                        input bit cy);
    desc_base = b; desc_x_m1 = xm1; desc_y_m1 = ym1; desc_stride = st;
    desc_cyclic = cy; desc_valid = 1'b1;
    #1;
    chk(desc_ready == 1'b1, "R10 ready idle", 32'(desc_ready), 32'd1);
    step(1'b0);
    desc_valid = 1'b0;
  endtask

  // Walk the full region 'passes' times; stall mode inserts back-pressure.
  task automatic run_desc(input logic [ADDR_W-1:0] b, input logic [X_W-1:0] xm1,
                          input logic [Y_W-1:0] ym1, input logic [STRIDE_W-1:0] st,
                          input bit cy, input int passes, input bit stall_on);
    logic [ADDR_W-1:0] ab, as, ea;
    int nb;
    ab = b & ~ADDR_W'(BB - 1);
    as = ADDR_W'(st) & ~ADDR_W'(BB - 1);
    nb = int'(xm1) / BB + 1;
    submit(b, xm1, ym1, st, cy);
    for (int p = 0; p < passes; p++)
      for (int r = 0; r <= int'(ym1); r++)
        for (int c = 0; c < nb; c++) begin
          ea = ab + ADDR_W'(r) * as + ADDR_W'(c * BB);
          take_beat(ea, c == nb - 1, (c == nb - 1) && (r == int'(ym1)),
                    stall_on ? (c + r + p) % 3 : 0);
        end
    if (!cy) begin
      #1;
      chk(beat_valid == 1'b0, "R10 idle after pass", 32'(beat_valid), 32'd0);
      chk(desc_ready == 1'b1, "R10 ready again", 32'(desc_ready), 32'd1);
    end else begin
      // R7: replay restarts at base; R8: stop with enable low on that beat.
      enable = 1'b0;
      take_beat(ab, nb == 1, (nb == 1) && (ym1 == 0), 0);
      #1;
      chk(beat_valid == 1'b0, "R8 abort", 32'(beat_valid), 32'd0);
      chk(desc_ready == 1'b0, "R10 not ready disabled", 32'(desc_ready), 32'd0);
      enable = 1'b1;
      #1;
      chk(desc_ready == 1'b1, "R8 back to idle", 32'(desc_ready), 32'd1);
    end
  endtask

  initial begin
    @(negedge clk);
    @(negedge clk);
    chk(beat_valid == 1'b0 && done == 1'b0, "R10 reset state",
        {30'd0, beat_valid, done}, 32'd0);
    chk(desc_ready == 1'b0, "R10 disabled not ready", 32'(desc_ready), 32'd0);
    rst_n = 1'b1;
    enable = 1'b1;
    @(negedge clk);
    // R1 R2 R3: sweep beats per row and row count, two strides, with and without stalls
    for (int nbv = 1; nbv <= 4; nbv++)
      for (int y = 0; y < 4; y++) begin
        run_desc(16'h0100, X_W'(nbv * BB - 1), Y_W'(y), STRIDE_W'(nbv * BB), 1'b0, 1, 1'b0);
        run_desc(16'hFFC0, X_W'(nbv * BB - 1), Y_W'(y), 12'h104, 1'b0, 1, 1'b1);
      end
    // R1: byte length not a multiple of the bus width rounds up (x_m1=5 -> 2 beats)
    run_desc(16'h0200, 8'd5, 4'd1, 12'h020, 1'b0, 1, 1'b0);
    // R5: misaligned base and stride have their low bits ignored
    run_desc(16'h0103, 8'd7, 4'd2, 12'h041, 1'b0, 1, 1'b1);
    // R4: single row, large stride ignored across replayed passes
    run_desc(16'h0400, 8'd11, 4'd0, 12'hFFC, 1'b1, 3, 1'b0);
    // R7: multi-row replay, done once per pass, with stalls
    run_desc(16'h0800, 8'd7, 4'd2, 12'h030, 1'b1, 2, 1'b1);
    // R8: disable mid-row, done must not fire
    submit(16'h0A00, 8'd15, 4'd1, 12'h040, 1'b0);
    take_beat(16'h0A00, 1'b0, 1'b0, 0);
    enable = 1'b0;
    take_beat(16'h0A04, 1'b0, 1'b0, 1);
    #1;
    chk(beat_valid == 1'b0, "R8 abort mid-row", 32'(beat_valid), 32'd0);
    enable = 1'b1;
    step(1'b0);
    // R10: a fresh descriptor after the abort starts at its own base
    run_desc(16'h0C00, 8'd3, 4'd1, 12'h010, 1'b0, 1, 1'b0);
    summary();
  end
endmodule